// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block collects interrupt requests from a parameterised set of board inputs, four timer inputs and four software-raised inter-processor sources. It presents one interrupt line to a single processor, and it hands out a vector number for each request. Every source has its own configuration word and a routing word. The configuration word holds the vector, a 4-bit priority, a mask bit and two bits that choose level or edge sensing and the active polarity. The routing word decides whether the source reaches processor 0.

Software reads the acknowledge register and gets back the vector of the best request that qualifies. The block marks that priority level as in service. When the handler finishes, software writes the end-of-interrupt register. A request can only interrupt when its priority is strictly above both the task-priority threshold and the highest level now in service. Because of this, a more urgent source can nest inside a handler that is already running. When nothing qualifies, the acknowledge read returns a programmable spurious vector.

A bit in the global configuration word switches the block into pass-through mode. In that mode the processor line simply follows board input 0, which is where an external legacy controller is wired.

Top module: `vpic`

## Requirements
- R1: After reset the block is in this state:
  - every source is masked, with configuration word 0x80000000, and no source is routed;
  - the task priority is 15, the spurious vector is 0xFF and the global word is 0;
  - `cpu_irq` is low, and an acknowledge read returns the spurious vector.
- R2: Register layout:
  - The configuration word of source i is at 0x100+16·i. Its fields are: bit 31 mask (1 = disabled), bit 23 polarity (1 = active high / rising), bit 22 sense (1 = level), bits 19:16 priority, and bits 7:0 vector. It reads back those fields, and every other bit reads 0.
  - The routing word is at 0x104+16·i. Bit 0 set routes the source to processor 0.
- R3: A source qualifies only when all of these hold:
  - it is pending, unmasked and routed;
  - its priority is strictly above the task priority (0x008);
  - its priority is strictly above the highest in-service level.
  Consequently, priority 0 never qualifies.
- R4: Among qualifying sources the highest priority wins. Ties go to the lowest source index. Source indices are: board inputs 0..N_EXT-1, then timers, then inter-processor sources.
- R5: An acknowledge read (0x00C) returns the winner's vector and marks its priority in service. `cpu_irq` then drops unless a strictly higher request exists. An edge-latched request is cleared by its acknowledge.
- R6: An acknowledge read with no qualifying request returns the spurious vector (0x004) and changes no state.
- R7: A write of any value to 0x010 retires the highest in-service level, so blocked lower requests become deliverable again.
- R8: A request with priority above the level in service asserts `cpu_irq` and is acknowledged while the lower one is still in service.
- R9: Sensing behaviour:
  - In level mode (bit 22 = 1), a request is pending while the input equals bit 23.
  - In edge mode (bit 22 = 0), a rising edge (bit 23 = 1) or a falling edge (bit 23 = 0) is latched until it is acknowledged.
- R10: The task priority register keeps only bits 3:0 of a write.
- R11: A write with bit 0 set to 0x040+16·k raises inter-processor source k as an edge request. A write with bit 0 clear has no effect.
- R12: Bit 29 of the global word (0x000) selects pass-through:
  - `cpu_irq` follows `ext_irq[0]`, and vectored delivery is suppressed.
  - Clearing the bit restores vectored delivery.
- R13: Read data appears on `bus_rdata` with `bus_rvalid` one cycle after `bus_rd`. Read and write never occur in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Register byte address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| bus_rvalid | output | 1 | Read data valid |
| ext_irq | input | N_EXT | Board interrupt inputs |
| tmr_irq | input | N_TMR | Timer interrupt inputs |
| cpu_irq | output | 1 | Interrupt request to processor 0 |

## Verification
Several properties are checked on every cycle:
- the in-service tracker only accepts a level above its current top, records it, and drops strictly on retirement;
- an edge latch holds until cleared;
- a blocked acknowledge returns the spurious vector;
- `cpu_irq` falls after an acknowledge unless a strictly higher request is present.

Other behaviours only the scenarios can show, because they need chosen stimulus and expected vectors:
- tie-breaking by index;
- task-priority masking;
- routing and mask gating;
- falling-edge latching while masked;
- inter-processor dispatch;
- pass-through mode.

// File: rtl/vpic_pkg.sv
package vpic_pkg;
   // global register offsets
   localparam int OFF_GCFG   = 'h000;
   localparam int OFF_SPUR   = 'h004;
   localparam int OFF_TASK   = 'h008;
   localparam int OFF_ACK    = 'h00C;
   localparam int OFF_EOI    = 'h010;
   // inter-processor dispatch block
   localparam int IPI_BASE   = 'h040;
   localparam int IPI_STRIDE = 16;
   // per-source block
   localparam int SRC_BASE   = 'h100;
   localparam int SRC_STRIDE = 16;
   localparam int DST_OFS    = 4;
   // field positions
   localparam int B_MASK     = 31;
   localparam int B_CASC     = 29;
   localparam int B_POL      = 23;
   localparam int B_LVL      = 22;
   localparam int B_PRI      = 16;
endpackage

// File: rtl/vpic_sense.sv
module vpic_sense (
   input  logic clk,
   input  logic rst_n,
   input  logic raw_i,
   input  logic lvl_i,
   input  logic hi_i,
   input  logic clr_i,
   output logic pend_o
);
   logic prev_q, latch_q, edge_ev;

   assign edge_ev = hi_i ? (raw_i & ~prev_q) : (~raw_i & prev_q);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         prev_q  <= 1'b0;
         latch_q <= 1'b0;
      end else begin
         prev_q <= raw_i;
         if (edge_ev && !lvl_i) latch_q <= 1'b1;
         else if (clr_i)        latch_q <= 1'b0;
      end
   end

   assign pend_o = lvl_i ? (raw_i == hi_i) : latch_q;

   AST_EDGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (latch_q && !clr_i) |=> latch_q);                                 // R9
endmodule

// File: rtl/vpic_arb.sv
module vpic_arb #(
   parameter int NSRC  = 12,
   parameter int PRI_W = 4,
   parameter int IDX_W = 4
) (
   input  logic [NSRC-1:0]            elig_i,
   input  logic [NSRC-1:0][PRI_W-1:0] pri_i,
   output logic                       vld_o,
   output logic [IDX_W-1:0]           idx_o,
   output logic [PRI_W-1:0]           pri_o
);
   // linear scan; strict compare keeps the lowest index on ties
   always_comb begin
      vld_o = 1'b0;
      idx_o = '0;
      pri_o = '0;
      for (int i = 0; i < NSRC; i++) begin
         if (elig_i[i] && (!vld_o || pri_i[i] > pri_o)) begin
            vld_o = 1'b1;
            idx_o = IDX_W'(i);
            pri_o = pri_i[i];
         end
      end
   end
endmodule

// File: rtl/vpic_isr.sv
module vpic_isr #(
   parameter int PRI_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push_i,
   input  logic [PRI_W-1:0] push_pri_i,
   input  logic             pop_i,
   output logic [PRI_W-1:0] top_o
);
   localparam int LVLS = 1 << PRI_W;

   logic [LVLS-1:0] act_q, act_d;

   always_comb begin
      top_o = '0;
      for (int l = 0; l < LVLS; l++)
         if (act_q[l]) top_o = PRI_W'(l);
   end

   always_comb begin
      act_d = act_q;
      if (pop_i)  act_d[top_o]      = 1'b0;
      if (push_i) act_d[push_pri_i] = 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) act_q <= '0;
      else        act_q <= act_d;
   end

   AST_PUSH_ABOVE_TOP: assert property (@(posedge clk) disable iff (!rst_n)
      push_i |-> (push_pri_i > top_o));                                 // R8
   AST_PUSH_MARKS: assert property (@(posedge clk) disable iff (!rst_n)
      push_i |=> (top_o == $past(push_pri_i)));                          // R5
   AST_POP_LOWERS: assert property (@(posedge clk) disable iff (!rst_n)
      (pop_i && !push_i && top_o != '0) |=> (top_o < $past(top_o)));     // R7
endmodule

// File: rtl/vpic.sv
module vpic #(
   parameter int N_EXT  = 4,
   parameter int N_TMR  = 4,
   parameter int N_IPI  = 4,
   parameter int PRI_W  = 4,
   parameter int VEC_W  = 8,
   parameter int ADDR_W = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   output logic              bus_rvalid,
   input  logic [N_EXT-1:0]  ext_irq,
   input  logic [N_TMR-1:0]  tmr_irq,
   output logic              cpu_irq
);
   import vpic_pkg::*;

   localparam int NSRC   = N_EXT + N_TMR + N_IPI;
   localparam int IDX_W  = (NSRC > 1) ? $clog2(NSRC) : 1;
   localparam int TMR_LO = N_EXT;
   localparam int IPI_LO = N_EXT + N_TMR;

   if (PRI_W < 1 || PRI_W > 4) begin : g_bad_pri
      $error("PRI_W must lie in 1..4");
   end
   if (VEC_W < 1 || VEC_W > 16) begin : g_bad_vec
      $error("VEC_W must lie in 1..16");
   end
   if (N_EXT < 1 || N_IPI < 1 || N_IPI > 12) begin : g_bad_cnt
      $error("source counts out of range");
   end
   if (SRC_BASE + SRC_STRIDE * NSRC > (1 << ADDR_W)) begin : g_bad_addr
      $error("ADDR_W too small for the source block");
   end

   logic             casc_q;
   logic [VEC_W-1:0] spur_q;
   logic [PRI_W-1:0] task_q;
   logic             msk_q [NSRC];
   logic             pol_q [NSRC];
   logic             lvl_q [NSRC];
   logic             dst_q [NSRC];
   logic [PRI_W-1:0] pri_q [NSRC];
   logic [VEC_W-1:0] vec_q [NSRC];

   logic [NSRC-1:0]            pend, clr, elig;
   logic [NSRC-1:0][PRI_W-1:0] pri_pk;
   logic [N_IPI-1:0]           ipi_go;
   logic                       sel_vld;
   logic [IDX_W-1:0]           sel_idx;
   logic [PRI_W-1:0]           sel_pri, top_pri;
   logic                       ack_rd, eoi_wr, deliver, ack_deliv;
   logic [31:0]                rd_val;
   logic                       unused_wd;

   assign unused_wd = ^bus_wdata;

   assign ack_rd    = bus_rd && bus_addr == ADDR_W'(OFF_ACK);
   assign eoi_wr    = bus_wr && bus_addr == ADDR_W'(OFF_EOI);
   assign deliver   = !casc_q && sel_vld && sel_pri > task_q && sel_pri > top_pri;
   assign ack_deliv = ack_rd && deliver;
   assign cpu_irq   = casc_q ? ext_irq[0] : deliver;

   // global registers
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         casc_q <= 1'b0;
         spur_q <= '1;
         task_q <= '1;
      end else if (bus_wr) begin
         if (bus_addr == ADDR_W'(OFF_GCFG)) casc_q <= bus_wdata[B_CASC];
         if (bus_addr == ADDR_W'(OFF_SPUR)) spur_q <= bus_wdata[VEC_W-1:0];
         if (bus_addr == ADDR_W'(OFF_TASK)) task_q <= bus_wdata[PRI_W-1:0];
      end
   end

   for (genvar k = 0; k < N_IPI; k++) begin : g_ipi
      assign ipi_go[k] = bus_wr && bus_wdata[0] &&
                         bus_addr == ADDR_W'(IPI_BASE + IPI_STRIDE * k);
   end

   // per-source configuration and sensing
   for (genvar g = 0; g < NSRC; g++) begin : g_src
      localparam logic [ADDR_W-1:0] A_VP  = ADDR_W'(SRC_BASE + SRC_STRIDE * g);
      localparam logic [ADDR_W-1:0] A_DST = ADDR_W'(SRC_BASE + SRC_STRIDE * g + DST_OFS);
      logic raw, lvl, hi;

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            msk_q[g] <= 1'b1;
            pol_q[g] <= 1'b0;
            lvl_q[g] <= 1'b0;
            dst_q[g] <= 1'b0;
            pri_q[g] <= '0;
            vec_q[g] <= '0;
         end else if (bus_wr && bus_addr == A_VP) begin
            msk_q[g] <= bus_wdata[B_MASK];
            pol_q[g] <= bus_wdata[B_POL];
            lvl_q[g] <= bus_wdata[B_LVL];
            pri_q[g] <= bus_wdata[B_PRI +: PRI_W];
            vec_q[g] <= bus_wdata[VEC_W-1:0];
         end else if (bus_wr && bus_addr == A_DST) begin
            dst_q[g] <= bus_wdata[0];
         end
      end

      if (g < TMR_LO) begin : g_board
         assign raw = ext_irq[g];
         assign lvl = lvl_q[g];
         assign hi  = pol_q[g];
      end else if (g < IPI_LO) begin : g_timer
         assign raw = tmr_irq[g - TMR_LO];
         assign lvl = lvl_q[g];
         assign hi  = pol_q[g];
      end else begin : g_soft
         assign raw = ipi_go[g - IPI_LO];
         assign lvl = 1'b0;
         assign hi  = 1'b1;
      end

      assign clr[g]    = ack_deliv && sel_idx == IDX_W'(g);
      assign elig[g]   = pend[g] && !msk_q[g] && dst_q[g];
      assign pri_pk[g] = pri_q[g];

      vpic_sense u_sense (
         .clk   (clk),
         .rst_n (rst_n),
         .raw_i (raw),
         .lvl_i (lvl),
         .hi_i  (hi),
         .clr_i (clr[g]),
         .pend_o(pend[g])
      );
   end

   vpic_arb #(.NSRC(NSRC), .PRI_W(PRI_W), .IDX_W(IDX_W)) u_arb (
      .elig_i(elig),
      .pri_i (pri_pk),
      .vld_o (sel_vld),
      .idx_o (sel_idx),
      .pri_o (sel_pri)
   );

   vpic_isr #(.PRI_W(PRI_W)) u_isr (
      .clk       (clk),
      .rst_n     (rst_n),
      .push_i    (ack_deliv),
      .push_pri_i(sel_pri),
      .pop_i     (eoi_wr),
      .top_o     (top_pri)
   );

   // read mux
   always_comb begin
      rd_val = '0;
      if (bus_addr == ADDR_W'(OFF_GCFG)) rd_val[B_CASC] = casc_q;
      if (bus_addr == ADDR_W'(OFF_SPUR)) rd_val = 32'(spur_q);
      if (bus_addr == ADDR_W'(OFF_TASK)) rd_val = 32'(task_q);
      if (bus_addr == ADDR_W'(OFF_ACK))
         rd_val = deliver ? 32'(vec_q[sel_idx]) : 32'(spur_q);
      for (int i = 0; i < NSRC; i++) begin
         if (bus_addr == ADDR_W'(SRC_BASE + SRC_STRIDE * i)) begin
            rd_val[B_MASK]           = msk_q[i];
            rd_val[B_POL]            = pol_q[i];
            rd_val[B_LVL]            = lvl_q[i];
            rd_val[B_PRI +: PRI_W]   = pri_q[i];
            rd_val[VEC_W-1:0]        = vec_q[i];
         end
         if (bus_addr == ADDR_W'(SRC_BASE + SRC_STRIDE * i + DST_OFS))
            rd_val[0] = dst_q[i];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         bus_rdata  <= '0;
         bus_rvalid <= 1'b0;
      end else begin
         bus_rvalid <= bus_rd;
         if (bus_rd) bus_rdata <= rd_val;
      end
   end

   AST_BUS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_rd && bus_wr));                                              // R13
   AST_SPUR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_rd && !deliver) |=> (bus_rdata == 32'($past(spur_q))));       // R6
   AST_ACK_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
      ack_deliv |=> (!cpu_irq || sel_pri > $past(sel_pri)));             // R5
endmodule

// File: tb/vpic_tb.sv
module vpic_tb;
   localparam int CLK_P = 10;
   localparam int WDOG  = 20000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [11:0] bus_addr = '0;
   logic        bus_wr = 1'b0, bus_rd = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        bus_rvalid;
   logic [3:0]  ext_irq = '0;
   logic [3:0]  tmr_irq = '0;
   logic        cpu_irq;

   int n_chk = 0, n_fail = 0;
   logic [31:0] exp_q [$];
   string       tag_q [$];

   always #(CLK_P/2) clk = ~clk;

   vpic u_dut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .bus_rvalid(bus_rvalid), .ext_irq(ext_irq), .tmr_irq(tmr_irq),
      .cpu_irq(cpu_irq)
   );

   // monitor: pops expected read data as results appear
   always @(negedge clk) begin
      if (rst_n && bus_rvalid) begin
         n_chk++;
         if (exp_q.size() == 0) begin
            n_fail++;
            $display("FAIL R13: unexpected read data %h, expected none", bus_rdata);
         end else begin
            logic [31:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            if (bus_rdata !== e) begin
               n_fail++;
               $display("FAIL %s: read got %h expected %h", t, bus_rdata, e);
            end
         end
      end
   end

   task automatic wr(input int a, input logic [31:0] d);
      @(negedge clk);
      bus_addr = 12'(a); bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input int a, input logic [31:0] e, input string t);
      @(negedge clk);
      exp_q.push_back(e); tag_q.push_back(t);
      bus_addr = 12'(a); bus_rd = 1'b1;
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   task automatic chk_irq(input logic e, input string t);
      repeat (2) @(negedge clk);
      n_chk++;
      if (cpu_irq !== e) begin
         n_fail++;
         $display("FAIL %s: cpu_irq got %b expected %b", t, cpu_irq, e);
      end
   endtask

   task automatic set_ext(input int i, input logic v);
      @(negedge clk);
      ext_irq[i] = v;
      @(negedge clk);
   endtask

   function automatic int vp(input int s);  return 'h100 + 16*s; endfunction
   function automatic int dst(input int s); return 'h104 + 16*s; endfunction

   localparam int ACK = 'h00C, EOI = 'h010, TSK = 'h008, SPR = 'h004, GCF = 'h000;

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      chk_irq(1'b0, "R1 irq idle");
      rd(TSK, 32'hF, "R1 task reset");
      rd(vp(2), 32'h8000_0000, "R1 masked");
      rd(dst(2), 32'h0, "R1 unrouted");
      rd(SPR, 32'hFF, "R1 spurious reset");
      rd(GCF, 32'h0, "R1 gcfg reset");
      rd(ACK, 32'hFF, "R1 ack spurious");
      // R10 task width, R13 read path
      wr(SPR, 32'h3C);
      rd(SPR, 32'h3C, "R13 readback");
      wr(TSK, 32'h25);
      rd(TSK, 32'h5, "R10 task bits");
      wr(TSK, 0);
      // R2 field layout
      wr(vp(1), 32'h0F05_1F21);
      rd(vp(1), 32'h0005_0021, "R2 fields only");
      wr(vp(1), 32'h00C5_0021);
      rd(vp(1), 32'h00C5_0021, "R2 readback");
      set_ext(1, 1'b1);
      chk_irq(1'b0, "R3 unrouted");
      wr(dst(1), 1);
      rd(dst(1), 1, "R2 dest");
      chk_irq(1'b1, "R3 routed");
      rd(ACK, 32'h21, "R5 vector");
      chk_irq(1'b0, "R5 drop after ack");
      wr(EOI, 0);
      chk_irq(1'b1, "R7 eoi releases");
      rd(ACK, 32'h21, "R5 vector again");
      set_ext(1, 1'b0);
      wr(EOI, 0);
      chk_irq(1'b0, "R9 level follows");
      // R3 task priority
      wr(TSK, 5);
      set_ext(1, 1'b1);
      chk_irq(1'b0, "R3 task equal blocks");
      wr(TSK, 4);
      chk_irq(1'b1, "R3 task below passes");
      rd(ACK, 32'h21, "R3 ack");
      set_ext(1, 1'b0);
      wr(EOI, 0);
      wr(TSK, 0);
      chk_irq(1'b0, "R3 quiet");
      // R8 nesting: timer 0 (source 4) rising edge, priority 9
      wr(vp(4), 32'h0089_0044);
      wr(dst(4), 1);
      set_ext(1, 1'b1);
      rd(ACK, 32'h21, "R8 low first");
      @(negedge clk); tmr_irq[0] = 1'b1;
      chk_irq(1'b1, "R8 nest request");
      rd(ACK, 32'h44, "R8 nested vector");
      chk_irq(1'b0, "R8 drop");
      rd(ACK, 32'h3C, "R6 blocked spurious");
      @(negedge clk); tmr_irq[0] = 1'b0;
      wr(EOI, 0);
      chk_irq(1'b0, "R7 level 5 still busy");
      wr(EOI, 0);
      chk_irq(1'b1, "R7 lower released");
      set_ext(1, 1'b0);
      chk_irq(1'b0, "R9 level drop, R5 edge cleared");
      // R4 ties and priority
      wr(vp(2), 32'h00C7_0032); wr(dst(2), 1);
      wr(vp(3), 32'h00C7_0033); wr(dst(3), 1);
      @(negedge clk); ext_irq[2] = 1'b1; ext_irq[3] = 1'b1;
      rd(ACK, 32'h32, "R4 tie lowest index");
      wr(EOI, 0);
      wr(vp(3), 32'h00C8_0033);
      rd(ACK, 32'h33, "R4 higher wins");
      wr(EOI, 0);
      @(negedge clk); ext_irq[2] = 1'b0; ext_irq[3] = 1'b0;
      chk_irq(1'b0, "R4 quiet");
      // R9 falling edge on source 0, R3 mask
      wr(vp(0), 32'h0003_0010); wr(dst(0), 1);
      set_ext(0, 1'b1);
      chk_irq(1'b0, "R9 rising ignored");
      set_ext(0, 1'b0);
      chk_irq(1'b1, "R9 falling latched");
      rd(ACK, 32'h10, "R9 edge vector");
      wr(EOI, 0);
      chk_irq(1'b0, "R5 edge cleared by ack");
      wr(vp(0), 32'h8003_0010);
      set_ext(0, 1'b1);
      set_ext(0, 1'b0);
      chk_irq(1'b0, "R3 masked");
      wr(vp(0), 32'h0003_0010);
      chk_irq(1'b1, "R3 unmask shows latched");
      rd(ACK, 32'h10, "R3 ack latched");
      wr(EOI, 0);
      // R11 inter-processor dispatch (sources 8..11)
      wr(vp(8), 32'h000C_0080); wr(dst(8), 1);
      wr(vp(9), 32'h000C_0081); wr(dst(9), 1);
      wr('h050, 0);
      chk_irq(1'b0, "R11 bit0 clear ignored");
      wr('h050, 1);
      chk_irq(1'b1, "R11 dispatch raises");
      rd(ACK, 32'h81, "R11 vector");
      wr(EOI, 0);
      chk_irq(1'b0, "R11 retired");
      wr(vp(10), 32'h0000_0082); wr(dst(10), 1);
      wr('h060, 1);
      chk_irq(1'b0, "R3 priority zero");
      rd(ACK, 32'h3C, "R6 nothing qualifies");
      // R12 pass-through
      wr(GCF, 32'h2000_0000);
      rd(GCF, 32'h2000_0000, "R12 readback");
      set_ext(1, 1'b1);
      chk_irq(1'b0, "R12 vectored suppressed");
      set_ext(0, 1'b1);
      chk_irq(1'b1, "R12 follows input high");
      set_ext(0, 1'b0);
      chk_irq(1'b0, "R12 follows input low");
      wr(GCF, 0);
      rd(ACK, 32'h21, "R12 vectored restored");
      repeat (4) @(negedge clk);
      if (exp_q.size() != 0) begin
         n_chk++; n_fail++;
         $display("FAIL R13: %0d reads missing, expected 0", exp_q.size());
      end
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (WDOG) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog: cycles %0d expected fewer", WDOG);
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end
endmodule